// File: doc/BRIEF.md
# Edge Timestamp Capture Unit

This peripheral records when a single asynchronous input changes level. A free-running counter advances once per module clock. Each qualifying edge on the input stores the counter value into the next of four capture slots. Every slot has its own choice of rising or falling edge, so a full rotation can measure periods, pulse widths or duty cycle directly. Software reaches the block through a plain 32-bit register port with address, write strobe, write data and combinational read data.

The sequencer runs in one of two modes. In continuous mode it cycles through the slots without end. In one-shot mode it stops after a programmable slot and stays idle until software re-arms it. Five events feed a sticky flag set: one per slot, plus counter wraparound. Each flag has an enable, a clear bit and a force bit. A global flag drives the interrupt line.

Top module: `edge_stamp_unit`

## Requirements
- R1: While control bit 20 (run) is 1, the counter at byte offset 0x00 rises by one every clock. While it is 0, the counter holds its value.
- R2: A write to offset 0x00 loads the counter. The written value is read back in the next cycle, even while the counter is running.
- R3: The input passes through a two-flop synchronizer. A capture stores the counter value of the cycle in which the synchronized edge is seen. The new value is readable after the third rising clock edge that follows the input change, and not before.
- R4: Control bit 2*i sets the edge for slot i: 1 selects falling and 0 selects rising. An edge of the other direction is ignored and does not advance the slot pointer.
- R5: Slots fill in order 0,1,2,3, at offsets 0x08+4*i. In continuous mode (control bit 16 = 0) the pointer wraps from slot 3 to slot 0 and overwrites it.
- R6: In one-shot mode (bit 16 = 1), capture stops once the slot given by bits 18:17 is written, and later edges are ignored. Writing 1 to bit 19 resets the pointer to slot 0 and arms capture again.
- R7: While control bit 8 (load enable) is 0, no slot is written and no capture flag is set.
- R8: When the running counter wraps from all ones to zero, the overflow flag (event 4) is set.
- R9: In the word at 0x2C, bit i+1 enables event i (events 0..3 are slots 0..3, event 4 is overflow), bit i+17 is the flag of event i, and bit 16 is the global flag. The global flag, and with it irq_o, is set only by an event whose enable is 1.
- R10: In the word at 0x30, writing 1 to bit 0 clears the global flag and writing 1 to bit i+1 clears the flag of event i. Bits written as 0 leave their flags unchanged.
- R11: Writing 1 to bit i+21 of the word at 0x30 sets the flag of event i, and also the global flag when event i is enabled.
- R12: If an event occurs in the same cycle as a write that clears its flag, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 7 | Byte address of the register access |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| cap_i | input | 1 | Asynchronous input to be timestamped |
| irq_o | output | 1 | Interrupt request (global flag) |

## Verification
The bench uses the default parameters: a 32-bit counter, four slots and a two-stage synchronizer. It reaches the wraparound in a few cycles by loading the counter just below all ones, since the write path reaches every counter value. Captures are taken with the counter frozen at a freshly written value, so each slot holds a known, distinct stamp. This makes the slot order, the polarity skips, the one-shot stop and the synchronizer latency exact to the cycle.

// File: rtl/esu_pkg.sv
`timescale 1ns/1ps
package esu_pkg;
  localparam int unsigned BUS_W   = 32;
  localparam int unsigned ADDR_W  = 7;
  localparam int unsigned NUM_EVT = 5;

  localparam logic [ADDR_W-1:0] OFF_CNT = 7'h00;
  localparam logic [ADDR_W-1:0] OFF_CAP = 7'h08;
  localparam logic [ADDR_W-1:0] OFF_CTL = 7'h28;
  localparam logic [ADDR_W-1:0] OFF_INT = 7'h2C;
  localparam logic [ADDR_W-1:0] OFF_CLR = 7'h30;

  localparam int unsigned CTL_LOAD    = 8;
  localparam int unsigned CTL_ONESHOT = 16;
  localparam int unsigned CTL_STOP_LO = 17;
  localparam int unsigned CTL_REARM   = 19;
  localparam int unsigned CTL_RUN     = 20;

  localparam int unsigned INT_EN_LO  = 1;
  localparam int unsigned INT_GFLAG  = 16;
  localparam int unsigned INT_FLG_LO = 17;

  localparam int unsigned CLR_GLOBAL = 0;
  localparam int unsigned CLR_LO     = 1;
  localparam int unsigned FRC_LO     = 21;
endpackage

// File: rtl/esu_edge_detect.sv
`timescale 1ns/1ps
module esu_edge_detect #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cap_i,
  output logic rise_o,
  output logic fall_o
);
  // sh[STAGES-1] is the synchronized level, sh[STAGES] its previous value
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], cap_i};
  end

  assign rise_o =  sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall_o = ~sh_q[STAGES-1] &  sh_q[STAGES];
endmodule

// File: rtl/esu_capture_seq.sv
`timescale 1ns/1ps
module esu_capture_seq #(
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned NUM_SLOTS = 4,
  localparam int unsigned SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            rise_i,
  input  logic                            fall_i,
  input  logic [NUM_SLOTS-1:0]            pol_i,
  input  logic                            load_en_i,
  input  logic                            oneshot_i,
  input  logic [SLOT_W-1:0]               stop_i,
  input  logic                            rearm_i,
  input  logic [CNT_W-1:0]                cnt_i,
  output logic [NUM_SLOTS-1:0][CNT_W-1:0] cap_o,
  output logic [NUM_SLOTS-1:0]            evt_o,
  output logic [SLOT_W-1:0]               ptr_o,
  output logic                            armed_o,
  output logic                            fire_o
);
  logic [SLOT_W-1:0] ptr_q;
  logic              armed_q;
  logic              hit;

  assign hit    = pol_i[ptr_q] ? fall_i : rise_i;
  // re-arm takes priority over a coincident edge
  assign fire_o = hit & load_en_i & armed_q & ~rearm_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q   <= '0;
      armed_q <= 1'b1;
    end else if (rearm_i) begin
      ptr_q   <= '0;
      armed_q <= 1'b1;
    end else if (fire_o) begin
      ptr_q <= ptr_q + 1'b1;
      if (oneshot_i && ptr_q == stop_i) armed_q <= 1'b0;
    end
  end

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    assign evt_o[g] = fire_o && (ptr_q == SLOT_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       cap_o[g] <= '0;
      else if (evt_o[g]) cap_o[g] <= cnt_i;
    end
  end

  assign ptr_o   = ptr_q;
  assign armed_o = armed_q;
endmodule

// File: rtl/esu_irq_ctrl.sv
`timescale 1ns/1ps
module esu_irq_ctrl #(
  parameter int unsigned NUM_EVT = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic [NUM_EVT-1:0] frc_i,
  input  logic [NUM_EVT-1:0] clr_i,
  input  logic               clr_global_i,
  input  logic               en_wr_i,
  input  logic [NUM_EVT-1:0] en_wdata_i,
  output logic [NUM_EVT-1:0] en_o,
  output logic [NUM_EVT-1:0] flag_o,
  output logic [NUM_EVT-1:0] set_o,
  output logic               global_o
);
  logic [NUM_EVT-1:0] en_q, flag_q;
  logic               global_q;

  assign set_o = evt_i | frc_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= '0;
      flag_q   <= '0;
      global_q <= 1'b0;
    end else begin
      if (en_wr_i) en_q <= en_wdata_i;
      // set dominates clear
      flag_q   <= (flag_q & ~clr_i) | set_o;
      global_q <= (global_q & ~clr_global_i) | (|(set_o & en_q));
    end
  end

  assign en_o     = en_q;
  assign flag_o   = flag_q;
  assign global_o = global_q;
endmodule

// File: rtl/edge_stamp_unit.sv
`timescale 1ns/1ps
module edge_stamp_unit #(
  parameter int unsigned CNT_W       = 32,
  parameter int unsigned NUM_SLOTS   = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [esu_pkg::ADDR_W-1:0] addr_i,
  input  logic                       we_i,
  input  logic [esu_pkg::BUS_W-1:0]  wdata_i,
  output logic [esu_pkg::BUS_W-1:0]  rdata_o,
  input  logic                       cap_i,
  output logic                       irq_o
);
  import esu_pkg::*;
  localparam int unsigned SLOT_W = $clog2(NUM_SLOTS);

  logic [CNT_W-1:0]               cnt_q, cnt_wdata;
  logic                           cnt_wr, ctl_wr, int_wr, clr_wr, rearm;
  logic [NUM_SLOTS-1:0]           pol_q;
  logic                           load_q, oneshot_q, ctl_run_q;
  logic [SLOT_W-1:0]              stop_q, slot_ptr;
  logic                           rise, fall, cap_fire, seq_armed, ovf_evt;
  logic [NUM_SLOTS-1:0][CNT_W-1:0] cap_val;
  logic [NUM_SLOTS-1:0]           cap_evt;
  logic [NUM_EVT-1:0]             evt_en, evt_flags, evt_set;
  logic [BUS_W-1:0]               ctl_rd, int_rd;

  assign cnt_wr    = we_i && addr_i == OFF_CNT;
  assign ctl_wr    = we_i && addr_i == OFF_CTL;
  assign int_wr    = we_i && addr_i == OFF_INT;
  assign clr_wr    = we_i && addr_i == OFF_CLR;
  assign rearm     = ctl_wr && wdata_i[CTL_REARM];
  assign cnt_wdata = wdata_i[CNT_W-1:0];

  // timestamp counter: a write overrides the increment
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (cnt_wr)    cnt_q <= cnt_wdata;
    else if (ctl_run_q) cnt_q <= cnt_q + 1'b1;
  end
  assign ovf_evt = ctl_run_q && !cnt_wr && (&cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pol_q     <= '0;
      load_q    <= 1'b0;
      oneshot_q <= 1'b0;
      stop_q    <= '0;
      ctl_run_q <= 1'b0;
    end else if (ctl_wr) begin
      for (int i = 0; i < NUM_SLOTS; i++) pol_q[i] <= wdata_i[2*i];
      load_q    <= wdata_i[CTL_LOAD];
      oneshot_q <= wdata_i[CTL_ONESHOT];
      stop_q    <= wdata_i[CTL_STOP_LO +: SLOT_W];
      ctl_run_q <= wdata_i[CTL_RUN];
    end
  end

  esu_edge_detect #(.STAGES(SYNC_STAGES)) edge_i (
    .clk_i (clk_i), .rst_ni(rst_ni), .cap_i(cap_i),
    .rise_o(rise),  .fall_o(fall)
  );

  esu_capture_seq #(.CNT_W(CNT_W), .NUM_SLOTS(NUM_SLOTS)) seq_i (
    .clk_i    (clk_i),     .rst_ni   (rst_ni),
    .rise_i   (rise),      .fall_i   (fall),
    .pol_i    (pol_q),     .load_en_i(load_q),
    .oneshot_i(oneshot_q), .stop_i   (stop_q),
    .rearm_i  (rearm),     .cnt_i    (cnt_q),
    .cap_o    (cap_val),   .evt_o    (cap_evt),
    .ptr_o    (slot_ptr),  .armed_o  (seq_armed),
    .fire_o   (cap_fire)
  );

  esu_irq_ctrl #(.NUM_EVT(NUM_EVT)) irq_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .evt_i       ({ovf_evt, cap_evt}),
    .frc_i       (clr_wr ? wdata_i[FRC_LO +: NUM_EVT] : '0),
    .clr_i       (clr_wr ? wdata_i[CLR_LO +: NUM_EVT] : '0),
    .clr_global_i(clr_wr && wdata_i[CLR_GLOBAL]),
    .en_wr_i     (int_wr),
    .en_wdata_i  (wdata_i[INT_EN_LO +: NUM_EVT]),
    .en_o        (evt_en),
    .flag_o      (evt_flags),
    .set_o       (evt_set),
    .global_o    (irq_o)
  );

  always_comb begin
    ctl_rd = '0;
    for (int i = 0; i < NUM_SLOTS; i++) ctl_rd[2*i] = pol_q[i];
    ctl_rd[CTL_LOAD]                = load_q;
    ctl_rd[CTL_ONESHOT]             = oneshot_q;
    ctl_rd[CTL_STOP_LO +: SLOT_W]   = stop_q;
    ctl_rd[CTL_RUN]                 = ctl_run_q;
    int_rd = '0;
    int_rd[INT_EN_LO +: NUM_EVT]    = evt_en;
    int_rd[INT_FLG_LO +: NUM_EVT]   = evt_flags;
    int_rd[INT_GFLAG]               = irq_o;
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFF_CNT: rdata_o = BUS_W'(cnt_q);
      OFF_CTL: rdata_o = ctl_rd;
      OFF_INT: rdata_o = int_rd;
      default: ;
    endcase
    for (int i = 0; i < NUM_SLOTS; i++)
      if (addr_i == OFF_CAP + ADDR_W'(4 * i)) rdata_o = BUS_W'(cap_val[i]);
  end
endmodule

// File: rtl/esu_checker.sv
`timescale 1ns/1ps
module esu_checker #(
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned NUM_SLOTS = 4,
  parameter int unsigned NUM_EVT   = 5,
  localparam int unsigned SLOT_W   = $clog2(NUM_SLOTS)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               ctl_run_q,
  input logic               cnt_wr,
  input logic [CNT_W-1:0]   cnt_q,
  input logic [CNT_W-1:0]   cnt_wdata,
  input logic               cap_fire,
  input logic               rearm,
  input logic [SLOT_W-1:0]  slot_ptr,
  input logic               seq_armed,
  input logic [NUM_EVT-1:0] evt_flags,
  input logic [NUM_EVT-1:0] evt_set,
  input logic [NUM_EVT-1:0] evt_en,
  input logic               irq_o
);
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctl_run_q && !cnt_wr) |=> $stable(cnt_q)); // R1
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_run_q && !cnt_wr) |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1)); // R1
  AST_CNT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_wr |=> cnt_q == $past(cnt_wdata)); // R2
  AST_PTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_fire |=> slot_ptr == SLOT_W'($past(slot_ptr) + 1'b1)); // R5
  AST_ONESHOT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!seq_armed && !rearm) |=> (!seq_armed && $stable(slot_ptr))); // R6
  AST_OVF_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_run_q && !cnt_wr && (&cnt_q)) |=> evt_flags[NUM_EVT-1]); // R8
  AST_IRQ_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(|(evt_set & evt_en))); // R9
  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_set) |=> ((evt_flags & $past(evt_set)) == $past(evt_set))); // R12
endmodule

bind edge_stamp_unit esu_checker #(
  .CNT_W(CNT_W), .NUM_SLOTS(NUM_SLOTS), .NUM_EVT(esu_pkg::NUM_EVT)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .ctl_run_q(ctl_run_q), .cnt_wr(cnt_wr),
  .cnt_q(cnt_q), .cnt_wdata(cnt_wdata), .cap_fire(cap_fire), .rearm(rearm),
  .slot_ptr(slot_ptr), .seq_armed(seq_armed), .evt_flags(evt_flags),
  .evt_set(evt_set), .evt_en(evt_en), .irq_o(irq_o)
);

// File: tb/edge_stamp_unit_tb_top.sv
`timescale 1ns/1ps
module edge_stamp_unit_tb_top;
  localparam logic [6:0]  A_CNT = 7'h00, A_CTL = 7'h28, A_INT = 7'h2C, A_CLR = 7'h30;
  localparam logic [31:0] C_LOAD = 32'h1 << 8, C_ONE = 32'h1 << 16, C_STOP1 = 32'h1 << 17,
                          C_REARM = 32'h1 << 19, C_RUN = 32'h1 << 20;
  localparam logic [31:0] FLG_MASK = 32'h003E_0000;

  logic        clk = 1'b0, rst_n = 1'b0, we = 1'b0, cap = 1'b0;
  logic [6:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        irq;

  typedef struct { bit is_irq; logic [31:0] mask; logic [31:0] exp; string tag; } item_t;
  item_t exp_q[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  edge_stamp_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we),
    .wdata_i(wdata), .rdata_o(rdata), .cap_i(cap), .irq_o(irq)
  );

  function automatic logic [6:0] a_cap(int i);
    return 7'(8 + 4 * i);
  endfunction

  // monitor: samples half a cycle after the driver, just before the next rising edge
  initial forever begin
    @(negedge clk);
    #2;
    while (exp_q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it  = exp_q.pop_front();
      act = it.is_irq ? {31'b0, irq} : (rdata & it.mask);
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: actual 0x%08h expected 0x%08h", it.tag, act, it.exp);
      end
    end
  end

  task automatic wr(logic [6:0] a, logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd_chk(logic [6:0] a, logic [31:0] m, logic [31:0] e, string tag);
    item_t it;
    addr = a;
    it.is_irq = 0; it.mask = m; it.exp = e; it.tag = tag;
    exp_q.push_back(it);
    @(negedge clk);
  endtask

  task automatic irq_chk(logic e, string tag);
    item_t it;
    it.is_irq = 1; it.mask = 32'h1; it.exp = {31'b0, e}; it.tag = tag;
    exp_q.push_back(it);
    @(negedge clk);
  endtask

  // load a frozen stamp, then move the input and let it propagate
  task automatic edge_cap(logic [31:0] stamp, logic lvl);
    wr(A_CNT, stamp);
    cap = lvl;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    rd_chk(A_CNT, '1, 0, "R1 reset count");
    rd_chk(A_CTL, '1, 0, "R6 reset control");
    rd_chk(A_INT, '1, 0, "R9 reset int word");
    rd_chk(a_cap(0), '1, 0, "R5 reset slot0");
    irq_chk(0, "R9 reset irq");

    // R1/R2: running counter, write wins
    wr(A_CTL, C_RUN | C_LOAD);
    wr(A_CNT, 32'd100);
    rd_chk(A_CNT, '1, 32'd100, "R2 load while running");
    rd_chk(A_CNT, '1, 32'd101, "R1 increment");
    wr(A_CTL, C_LOAD);
    wr(A_CNT, 32'd500);
    rd_chk(A_CNT, '1, 32'd500, "R2 load while frozen");
    rd_chk(A_CNT, '1, 32'd500, "R1 frozen hold");

    // R3: synchronizer latency
    wr(A_CNT, 32'h1111);
    cap = 1'b1;
    rd_chk(a_cap(0), '1, 0, "R3 edge+0");
    rd_chk(a_cap(0), '1, 0, "R3 edge+1");
    rd_chk(a_cap(0), '1, 0, "R3 edge+2");
    rd_chk(a_cap(0), '1, 32'h1111, "R3 captured");
    rd_chk(A_INT, FLG_MASK, 32'h1 << 17, "R9 slot0 flag");
    irq_chk(0, "R9 no enable no irq");

    // R4: slot1 rising, falling ignored
    edge_cap(32'h2222, 1'b0);
    rd_chk(a_cap(1), '1, 0, "R4 wrong edge ignored");
    wr(A_CTL, C_LOAD | (32'h1 << 2));
    edge_cap(32'h3333, 1'b1);
    rd_chk(a_cap(1), '1, 0, "R4 rise ignored on falling slot");
    edge_cap(32'h4444, 1'b0);
    rd_chk(a_cap(1), '1, 32'h4444, "R4 falling slot1");
    edge_cap(32'h5555, 1'b1);
    edge_cap(32'h6666, 1'b0);
    edge_cap(32'h7777, 1'b1);
    rd_chk(a_cap(2), '1, 32'h5555, "R5 slot2");
    rd_chk(a_cap(3), '1, 32'h7777, "R5 slot3 skip fall");
    edge_cap(32'h8888, 1'b0);
    edge_cap(32'h9999, 1'b1);
    rd_chk(a_cap(0), '1, 32'h9999, "R5 wrap overwrite slot0");
    rd_chk(a_cap(2), '1, 32'h5555, "R5 slot2 kept");
    rd_chk(A_INT, FLG_MASK, 32'h001E_0000, "R9 four capture flags");

    // R10: selective clear
    wr(A_CLR, 32'h1 << 1);
    rd_chk(A_INT, FLG_MASK, 32'h001C_0000, "R10 clear event0 only");
    wr(A_CLR, 32'h3F);
    rd_chk(A_INT, '1, 0, "R10 clear all");

    // R7: load disabled
    wr(A_CTL, 32'h0);
    edge_cap(32'hAAAA, 1'b0);
    edge_cap(32'hBBBB, 1'b1);
    rd_chk(a_cap(1), '1, 32'h4444, "R7 no load");
    rd_chk(A_INT, FLG_MASK, 0, "R7 no flags");

    // R6: one-shot stopping at slot1
    wr(A_CTL, C_LOAD | C_ONE | C_STOP1 | C_REARM);
    edge_cap(32'hC0, 1'b0);
    edge_cap(32'hC1, 1'b1);
    edge_cap(32'hC2, 1'b0);
    edge_cap(32'hC3, 1'b1);
    edge_cap(32'hC4, 1'b0);
    edge_cap(32'hC5, 1'b1);
    rd_chk(a_cap(0), '1, 32'hC1, "R6 slot0 after rearm");
    rd_chk(a_cap(1), '1, 32'hC3, "R6 stop slot");
    rd_chk(a_cap(2), '1, 32'h5555, "R6 ignored after stop");
    rd_chk(A_CTL, '1, C_LOAD | C_ONE | C_STOP1, "R6 control readback");
    wr(A_CTL, C_LOAD | C_ONE | C_STOP1 | C_REARM);
    edge_cap(32'hC6, 1'b0);
    edge_cap(32'hC7, 1'b1);
    rd_chk(a_cap(0), '1, 32'hC7, "R6 rearm restarts at slot0");

    // R9/R11: enables and force
    wr(A_CLR, 32'h3F);
    wr(A_INT, 32'h1 << 1);
    wr(A_CLR, 32'h1 << 22);
    rd_chk(A_INT, '1, (32'h1 << 18) | (32'h1 << 1), "R11 force disabled event");
    irq_chk(0, "R9 disabled event no irq");
    wr(A_CLR, 32'h1 << 21);
    rd_chk(A_INT, '1, (32'h3 << 17) | (32'h1 << 16) | (32'h1 << 1), "R11 force enabled event");
    irq_chk(1, "R9 irq raised");
    wr(A_CLR, 32'h1);
    rd_chk(A_INT, '1, (32'h3 << 17) | (32'h1 << 1), "R10 global clear keeps flags");
    irq_chk(0, "R10 irq cleared");
    wr(A_CLR, 32'h3F);

    // R8: wraparound
    wr(A_INT, 32'h1 << 5);
    wr(A_CTL, C_RUN);
    wr(A_CNT, 32'hFFFF_FFFE);
    rd_chk(A_INT, 32'h1 << 21, 0, "R8 no overflow yet");
    rd_chk(A_CNT, '1, 32'hFFFF_FFFF, "R1 reaches max");
    rd_chk(A_INT, (32'h1 << 21) | (32'h1 << 16), (32'h1 << 21) | (32'h1 << 16), "R8 overflow flag");
    irq_chk(1, "R8 overflow irq");
    wr(A_CLR, 32'h3F);

    // R12: capture coincides with clear of its flag
    wr(A_CTL, C_LOAD | C_REARM);
    cap = 1'b0;
    repeat (3) @(negedge clk);
    cap = 1'b1;
    repeat (2) @(negedge clk);
    wr(A_CLR, 32'h1 << 1);
    rd_chk(A_INT, 32'h1 << 17, 32'h1 << 17, "R12 set wins over clear");

    repeat (2) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule